// File: doc/BRIEF.md
# Serial-Commanded Actuator Column Pulse Driver

This block connects a host microcontroller to a 16 by 16 grid of pin actuators. The host sends fixed-length instruction packets over an SPI-style serial link: chip-select low, data valid on the rising clock edge, most significant bit first. Each packet carries an instruction number, a height code, a row position and an opcode. The block checks the packet's even parity and decodes it. With these packets the host loads per-row heights for the current column, fires that column, steps to the next column or clears the column.

Only one column is driven at a time. When a column is fired, each row's drive line stays high for a number of cycles set by its height code. That duration is what sets how far the pin rises. The pulse timing comes entirely from an internal timer and a programmable base tick count. Any packet that cannot be accepted, because of a parity fault or because a pulse is still running, is reported back to the host. The report is an error flag together with the offending instruction number.

Top module: `pin_column_driver`

## Requirements
- R1: A packet is exactly 19 bits, shifted MSB first while `spi_cs_n` is low and sampled on each rising `spi_sck`. The bit layout is parity[18], instruction number[17:10], height Z[9:7], row X[6:3], opcode[2:1], reserved[0]. A frame of any other length is dropped with no effect on any output.
- R2: Bits 18 down to 0 of a packet must hold an even number of ones. A packet that fails this check is not executed. Instead it sets `err` and loads its instruction number into `err_inst`.
- R3: Opcode 00 stores the height Z for row X of the current column. The stored value takes effect at the next fire.
- R4: Opcode 01 fires the column. Row i is driven high for (Z_i+1)·B consecutive cycles. Z_i = 0 leaves row i low. B is `base_ticks`, and a value of 0 is treated as 1.
- R5: A fire keeps `busy` high for exactly 8·B cycles, starting with the first driven cycle. `pwm` is high exactly when some row is driven. No row is ever driven while `busy` is low.
- R6: A packet that completes while `busy` is high is rejected like a parity failure (R2). It sets `err`, loads `err_inst` and has no other effect.
- R7: Opcode 10 advances `col_sel` by one, wrapping from 15 to 0. It pulses `col_inc` for one cycle and clears all stored heights. `col_sel` changes only together with a `col_inc` pulse.
- R8: Opcode 11 drives all 16 rows for 8·B cycles, with `col_rst` and `busy` high for the same span.
- R9: An accepted packet clears `err`.
- R10: After reset, all rows are low, `col_sel` is 0, and `busy`, `pwm`, `col_inc`, `col_rst`, `err` and `err_inst` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock, synchronous to clk, oversampled |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from host |
| base_ticks | input | 16 | Cycles per height step (0 acts as 1) |
| row_en | output | 16 | Row drive word for the selected column |
| col_sel | output | 4 | Index of the selected column |
| col_inc | output | 1 | One-cycle strobe when the column advances |
| col_rst | output | 1 | High while a column clear pulse runs |
| pwm | output | 1 | High while any row is driven |
| busy | output | 1 | High while a fire or clear pulse runs |
| err | output | 1 | Last packet was rejected |
| err_inst | output | 8 | Instruction number of the last rejected packet |

## Verification
Serial reception keeps running while a pulse is active, so a packet can complete in the middle of a fire. The bench provokes this with a long base tick and sends an advance packet during the pulse. It then checks that the error flag and instruction number are reported, that the row pulses still end on time, and that the column does not move. The bench also sends a packet that has a parity fault and arrives during a pulse, so both rejection causes apply to the same packet. It judges that the packet is reported exactly once, with its own instruction number, and changes nothing else.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

    localparam int FRAME_W = 19;
    localparam int INST_W  = 8;
    localparam int Z_W     = 3;
    localparam int X_W     = 4;

    typedef enum logic [1:0] {
        OP_SET   = 2'b00,
        OP_FIRE  = 2'b01,
        OP_NEXT  = 2'b10,
        OP_CLEAR = 2'b11
    } op_e;

    // packed from bit 18 down to bit 0
    typedef struct packed {
        logic              parity;
        logic [INST_W-1:0] inst;
        logic [Z_W-1:0]    z;
        logic [X_W-1:0]    x;
        op_e               op;
        logic              rsvd;
    } pkt_t;

    typedef struct packed {
        logic              accept;
        logic              reject;
        logic [INST_W-1:0] inst;
        logic [Z_W-1:0]    z;
        logic [X_W-1:0]    x;
        op_e               op;
    } cmd_t;

    typedef enum logic [1:0] {
        PG_IDLE,
        PG_FIRE,
        PG_CLEAR
    } pg_mode_e;

    function automatic logic even_ok(input logic [FRAME_W-1:0] f);
        return (^f) == 1'b0;
    endfunction

endpackage

// File: rtl/pcd_spi_rx.sv
module pcd_spi_rx #(
    parameter int FRAME_W = 19
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sck,
    input  logic               cs_n,
    input  logic               mosi,
    output logic               frame_vld,
    output logic [FRAME_W-1:0] frame
);
    localparam int CNT_MAX = FRAME_W + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic               sck_q, cs_q;
    logic [CNT_W-1:0]   bit_cnt;
    logic [FRAME_W-1:0] shreg;

    assign frame = shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q     <= 1'b0;
            cs_q      <= 1'b1;
            bit_cnt   <= '0;
            shreg     <= '0;
            frame_vld <= 1'b0;
        end else begin
            sck_q     <= sck;
            cs_q      <= cs_n;
            frame_vld <= 1'b0;
            if (!cs_n && sck && !sck_q) begin
                shreg <= {shreg[FRAME_W-2:0], mosi};
                if (bit_cnt != CNT_W'(CNT_MAX))
                    bit_cnt <= bit_cnt + 1'b1;
            end
            if (cs_n && !cs_q) begin
                frame_vld <= (bit_cnt == CNT_W'(FRAME_W));
                bit_cnt   <= '0;
            end
        end
    end

endmodule

// File: rtl/pcd_decode.sv
module pcd_decode
    import pcd_pkg::*;
(
    input  logic               frame_vld,
    input  logic [FRAME_W-1:0] frame,
    input  logic               busy,
    output cmd_t               cmd
);
    pkt_t pkt;
    logic bad;

    always_comb begin
        pkt        = pkt_t'(frame);
        bad        = !even_ok(frame);
        cmd.inst   = pkt.inst;
        cmd.z      = pkt.z;
        cmd.x      = pkt.x;
        cmd.op     = pkt.op;
        cmd.reject = frame_vld && (bad || busy);
        cmd.accept = frame_vld && !bad && !busy;
    end

endmodule

// File: rtl/pcd_pulse_gen.sv
module pcd_pulse_gen
    import pcd_pkg::*;
#(
    parameter int ROWS   = 16,
    parameter int TICK_W = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start_fire,
    input  logic                      start_clear,
    input  logic [TICK_W-1:0]         base_ticks,
    input  logic [ROWS-1:0][Z_W-1:0]  heights,
    output logic [ROWS-1:0]           row_en,
    output logic                      busy,
    output logic                      clear_act
);
    localparam logic [Z_W-1:0] SLOT_LAST = '1;

    pg_mode_e          mode;
    logic [TICK_W-1:0] base_q;
    logic [TICK_W-1:0] tick;
    logic [Z_W-1:0]    slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode   <= PG_IDLE;
            base_q <= '0;
            tick   <= '0;
            slot   <= '0;
        end else if (mode == PG_IDLE) begin
            if (start_fire || start_clear) begin
                mode   <= start_clear ? PG_CLEAR : PG_FIRE;
                base_q <= (base_ticks == '0) ? TICK_W'(1) : base_ticks;
                tick   <= '0;
                slot   <= '0;
            end
        end else begin
            if (tick == base_q - 1'b1) begin
                tick <= '0;
                if (slot == SLOT_LAST)
                    mode <= PG_IDLE;
                else
                    slot <= slot + 1'b1;
            end else begin
                tick <= tick + 1'b1;
            end
        end
    end

    assign busy      = (mode != PG_IDLE);
    assign clear_act = (mode == PG_CLEAR);

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign row_en[r] = clear_act ||
                           ((mode == PG_FIRE) && (heights[r] != '0) && (slot <= heights[r]));
    end

endmodule

// File: rtl/pin_column_driver.sv
module pin_column_driver
    import pcd_pkg::*;
#(
    parameter int ROWS   = 16,
    parameter int TICK_W = 16,
    localparam int COL_W = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    input  logic [TICK_W-1:0] base_ticks,
    output logic [ROWS-1:0]   row_en,
    output logic [COL_W-1:0]  col_sel,
    output logic              col_inc,
    output logic              col_rst,
    output logic              pwm,
    output logic              busy,
    output logic              err,
    output logic [INST_W-1:0] err_inst
);
    logic                     frame_vld;
    logic [FRAME_W-1:0]       frame;
    cmd_t                     cmd;
    logic [ROWS-1:0][Z_W-1:0] height_q;
    logic                     start_fire, start_clear;

    pcd_spi_rx #(.FRAME_W(FRAME_W)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .sck      (spi_sck),
        .cs_n     (spi_cs_n),
        .mosi     (spi_mosi),
        .frame_vld(frame_vld),
        .frame    (frame)
    );

    pcd_decode u_dec (
        .frame_vld(frame_vld),
        .frame    (frame),
        .busy     (busy),
        .cmd      (cmd)
    );

    assign start_fire  = cmd.accept && (cmd.op == OP_FIRE);
    assign start_clear = cmd.accept && (cmd.op == OP_CLEAR);

    always_ff @(posedge clk) begin
        if (rst) begin
            height_q <= '0;
            col_sel  <= '0;
            col_inc  <= 1'b0;
            err      <= 1'b0;
            err_inst <= '0;
        end else begin
            col_inc <= 1'b0;
            if (cmd.reject) begin
                err      <= 1'b1;
                err_inst <= cmd.inst;
            end else if (cmd.accept) begin
                err <= 1'b0;
                case (cmd.op)
                    OP_SET: begin
                        if (32'(cmd.x) < ROWS)
                            height_q[cmd.x] <= cmd.z;
                    end
                    OP_NEXT: begin
                        col_sel  <= (col_sel == COL_W'(ROWS - 1)) ? '0 : col_sel + 1'b1;
                        col_inc  <= 1'b1;
                        height_q <= '0;
                    end
                    default: ;
                endcase
            end
        end
    end

    pcd_pulse_gen #(.ROWS(ROWS), .TICK_W(TICK_W)) u_pg (
        .clk        (clk),
        .rst        (rst),
        .start_fire (start_fire),
        .start_clear(start_clear),
        .base_ticks (base_ticks),
        .heights    (height_q),
        .row_en     (row_en),
        .busy       (busy),
        .clear_act  (col_rst)
    );

    assign pwm = |row_en;

endmodule

// File: rtl/pcd_chk.sv
module pcd_chk #(
    parameter int ROWS  = 16,
    parameter int COL_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [ROWS-1:0]  row_en,
    input logic [COL_W-1:0] col_sel,
    input logic             col_inc,
    input logic             col_rst,
    input logic             busy
);
    // R5
    rows_need_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (row_en != '0) |-> busy);

    // R8
    clear_all_rows_chk: assert property (@(posedge clk) disable iff (rst)
        col_rst |-> (&row_en));

    // R6
    no_step_in_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        col_inc |-> !busy);

    // R7
    inc_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        col_inc |=> !col_inc);

    // R7
    col_moves_with_inc_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(col_sel) |-> col_inc);

endmodule

bind pin_column_driver pcd_chk #(.ROWS(ROWS), .COL_W(COL_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .row_en (row_en),
    .col_sel(col_sel),
    .col_inc(col_inc),
    .col_rst(col_rst),
    .busy   (busy)
);

// File: tb/sim_pin_column_driver.sv
module sim_pin_column_driver;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic [15:0] base = 16'd3;
    logic [15:0] row_en;
    logic [3:0]  col_sel;
    logic        col_inc, col_rst, pwm, busy, err;
    logic [7:0]  err_inst;

    int n_chk = 0, n_bad = 0;
    int rc[16];
    int busy_c, pwm_c, rst_c, inc_c;

    pin_column_driver u0 (
        .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .base_ticks(base), .row_en(row_en), .col_sel(col_sel), .col_inc(col_inc),
        .col_rst(col_rst), .pwm(pwm), .busy(busy), .err(err), .err_inst(err_inst)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [18:0] mk(input logic [7:0] inst, input logic [2:0] z,
                                       input logic [3:0] x, input logic [1:0] op);
        logic [18:0] f;
        f = {1'b0, inst, z, x, op, 1'b0};
        f[18] = ^f[17:0];
        return f;
    endfunction

    task automatic shift(input logic [18:0] f, input int nb);
        @(negedge clk) cs_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            mosi = f[18-i];
            sck = 1'b0;
            @(negedge clk);
            sck = 1'b1;
            @(negedge clk);
        end
        sck = 1'b0;
        @(negedge clk) cs_n = 1'b1;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic send(input logic [18:0] f);
        shift(f, 19);
        settle();
    endtask

    task automatic observe(input int n);
        for (int r = 0; r < 16; r++) rc[r] = 0;
        busy_c = 0; pwm_c = 0; rst_c = 0; inc_c = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            for (int r = 0; r < 16; r++) if (row_en[r]) rc[r]++;
            busy_c += int'(busy);
            pwm_c  += int'(pwm);
            rst_c  += int'(col_rst);
            inc_c  += int'(col_inc);
        end
    endtask

    task automatic t_reset();
        chk("R10 row_en", int'(row_en), 0);
        chk("R10 col_sel", int'(col_sel), 0);
        chk("R10 busy/pwm/inc/rst", int'({busy, pwm, col_inc, col_rst}), 0);
        chk("R10 err", int'(err), 0);
        chk("R10 err_inst", int'(err_inst), 0);
    endtask

    task automatic t_fire_pattern();
        base = 16'd3;
        send(mk(8'h01, 3'd1, 4'd0, 2'b00));
        send(mk(8'h02, 3'd7, 4'd5, 2'b00));
        send(mk(8'h03, 3'd3, 4'd9, 2'b00));
        send(mk(8'h04, 3'd0, 4'd2, 2'b00));
        shift(mk(8'h05, 3'd0, 4'd0, 2'b01), 19);
        observe(8*3 + 10);
        chk("R3 R4 row0 z=1", rc[0], 6);
        chk("R3 R4 row5 z=7", rc[5], 24);
        chk("R3 R4 row9 z=3", rc[9], 12);
        chk("R4 row2 z=0", rc[2], 0);
        chk("R4 row7 unset", rc[7], 0);
        chk("R5 busy length", busy_c, 24);
        chk("R5 pwm length", pwm_c, 24);
        chk("R8 no col_rst on fire", rst_c, 0);
    endtask

    task automatic t_base_zero();
        base = 16'd0;
        send(mk(8'h10, 3'd2, 4'd1, 2'b00));
        shift(mk(8'h11, 3'd0, 4'd0, 2'b01), 19);
        observe(8 + 10);
        chk("R4 base0 row1", rc[1], 3);
        chk("R5 base0 busy", busy_c, 8);
    endtask

    task automatic t_parity();
        logic [18:0] f;
        logic [3:0]  c0;
        c0 = col_sel;
        f = mk(8'hA5, 3'd0, 4'd0, 2'b10);
        f[18] = ~f[18];
        send(f);
        chk("R2 err set", int'(err), 1);
        chk("R2 err_inst", int'(err_inst), 8'hA5);
        chk("R2 no advance", int'(col_sel), int'(c0));
        send(mk(8'h20, 3'd0, 4'd0, 2'b00));
        chk("R9 err cleared", int'(err), 0);
    endtask

    task automatic t_short();
        logic [3:0] c0;
        c0 = col_sel;
        shift(mk(8'h30, 3'd0, 4'd0, 2'b10), 18);
        observe(12);
        chk("R1 short frame no inc", inc_c, 0);
        chk("R1 short frame col", int'(col_sel), int'(c0));
        chk("R1 short frame err", int'(err), 0);
    endtask

    task automatic t_busy_reject();
        logic [18:0] f;
        logic [3:0]  c0;
        c0 = col_sel;
        base = 16'd40;
        send(mk(8'h40, 3'd1, 4'd4, 2'b00));
        send(mk(8'h41, 3'd0, 4'd0, 2'b01));
        send(mk(8'h3C, 3'd0, 4'd0, 2'b10));
        chk("R6 still busy", int'(busy), 1);
        chk("R6 err set", int'(err), 1);
        chk("R6 err_inst", int'(err_inst), 8'h3C);
        f = mk(8'h77, 3'd5, 4'd4, 2'b00);
        f[18] = ~f[18];
        send(f);
        chk("R6 R2 combined err_inst", int'(err_inst), 8'h77);
        for (int k = 0; k < 400 && busy; k++) @(negedge clk);
        chk("R6 busy ended", int'(busy), 0);
        chk("R6 column held", int'(col_sel), int'(c0));
        base = 16'd2;
        shift(mk(8'h42, 3'd0, 4'd0, 2'b01), 19);
        observe(16 + 10);
        chk("R6 rejected height not stored", rc[4], 4);
    endtask

    task automatic t_advance();
        logic [3:0] c0;
        base = 16'd2;
        send(mk(8'h50, 3'd4, 4'd3, 2'b00));
        c0 = col_sel;
        shift(mk(8'h51, 3'd0, 4'd0, 2'b10), 19);
        observe(8);
        chk("R7 one inc pulse", inc_c, 1);
        chk("R7 col +1", int'(col_sel), int'(c0 + 4'd1));
        shift(mk(8'h52, 3'd0, 4'd0, 2'b01), 19);
        observe(16 + 10);
        chk("R7 heights cleared", rc[3], 0);
        for (int k = 0; k < 16 && col_sel != 4'd15; k++)
            send(mk(8'h53, 3'd0, 4'd0, 2'b10));
        chk("R7 reached 15", int'(col_sel), 15);
        send(mk(8'h54, 3'd0, 4'd0, 2'b10));
        chk("R7 wrap to 0", int'(col_sel), 0);
    endtask

    task automatic t_clear();
        int all_ok;
        base = 16'd2;
        shift(mk(8'h60, 3'd0, 4'd0, 2'b11), 19);
        observe(16 + 10);
        all_ok = 1;
        for (int r = 0; r < 16; r++) if (rc[r] != 16) all_ok = 0;
        chk("R8 all rows full length", all_ok, 1);
        chk("R8 col_rst length", rst_c, 16);
        chk("R8 busy length", busy_c, 16);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fire_pattern();
        t_base_zero();
        t_parity();
        t_short();
        t_busy_reject();
        t_advance();
        t_clear();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule